// File: doc/BRIEF.md
# Shared Ready/Data Serial Output Pin

This block drives one output pin that does two jobs for a converter. When a fresh 20-bit result is loaded, the pin falls low to tell the host that data is waiting. The host then toggles a shift clock. Each rising edge of that clock moves the pin on to the next result bit, starting with the most significant. Once the data bits run out, the pin reads as one. A host that polls the pin therefore sees a clean high line until the next result is ready.

The shift clock arrives from outside, asynchronous to the system clock. It passes through a two-flop synchronizer, and only its detected rising edges act on the logic, so all state changes on the system clock. A separate input marks the update window before each new result. While that marker is high the pin is forced high, and any result not yet fully read is dropped. A load strobe always restarts the readout with the new word, even in the middle of a readout.

Top module: `rdy_dout_port`

## Requirements
- R1: In the first cycle after reset is released, the pin is high and no result is pending.
- R2: In the cycle after a load strobe, the pin is low (ready) unless the update marker is high.
- R3: The first rising shift-clock edge after ready puts bit 19 (the MSB) of the loaded word on the pin.
- R4: Rising edge number k (k = 1..20) puts result bit 20-k on the pin, so the bits come MSB first and bit 0 comes last.
- R5: Rising edges 21 to 24, and any edge after those, leave the pin at 1. The edge counter never goes past 24.
- R6: With no update marker, no load and no detected edge, the pin keeps its value. After exactly 20 edges it therefore holds bit 0 until the update marker rises.
- R7: While the update marker is high, the pin is 1. Once the marker has cleared a pending result, the pin stays at 1 until the next load.
- R8: A load strobe during a readout drops the old word. The pin goes low, and the next edge shows the MSB of the new word.
- R9: A shift-clock rise acts on the pin at the third system-clock edge after it is first sampled. A level held high for many cycles counts as only one edge.
- R10: Shift-clock edges when no result is pending leave the pin at 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| load_stb | input | 1 | One-cycle strobe that loads a new result |
| load_data | input | 20 | Result word captured on load_stb |
| upd_win | input | 1 | High during the update window before a new result |
| sclk_in | input | 1 | External shift clock, asynchronous |
| dout_pin | output | 1 | Combined ready flag and serial data output |

## Verification
The checker watches several rules on every cycle. The update marker forces the pin high. A load leads to a low pin. Padding edges past bit 20 keep the pin high. The edge counter moves up by one per detected edge and stays within its limit. With no event, the pin holds its value. Only the bench scenarios, checked against the cycle model, can show the actual bit order of a word, the three-cycle synchronizer latency, the one-shift-per-level rule, and the effect of overwriting a word mid-readout.

// File: rtl/rdy_dout_pkg.sv
// Package: shared sizing for the ready/data output pin.
// Assumes a result word no wider than a few dozen bits.
package rdy_dout_pkg;
    parameter int DEF_DATA_W = 20;
    parameter int DEF_PAD_W  = 4;
    parameter int DEF_SYNC_N = 2;

    // Width of a counter that must reach max_val inclusive.
    function automatic int cnt_width(input int max_val);
        return (max_val < 2) ? 1 : $clog2(max_val + 1);
    endfunction
endpackage

// File: rtl/rdy_sync_edge.sv
// Module: synchronizes the external shift clock into clk and gives a
// one-cycle pulse per rising edge. Assumes the input is asynchronous.
module rdy_sync_edge #(
    parameter int SYNC_N = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic async_in,
    output logic rise_pulse
);
    logic [SYNC_N-1:0] chain;
    logic              last_q;

    // Synchronizer chain; stage 0 samples the raw input.
    generate
        for (genvar g = 0; g < SYNC_N; g++) begin : g_stage
            if (g == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (!rst_n) chain[0] <= 1'b0;
                    else        chain[0] <= async_in;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (!rst_n) chain[g] <= 1'b0;
                    else        chain[g] <= chain[g-1];
                end
            end
        end
    endgenerate

    // Delayed copy of the synchronized level for edge detection.
    always_ff @(posedge clk) begin
        if (!rst_n) last_q <= 1'b0;
        else        last_q <= chain[SYNC_N-1];
    end

    // Rising-edge pulse.
    always_comb rise_pulse = chain[SYNC_N-1] & ~last_q;
endmodule

// File: rtl/rdy_shift_core.sv
// Module: holds the result word, the edge counter and the pending flag.
// Assumes load_stb has priority over every other event in a cycle.
module rdy_shift_core #(
    parameter int DATA_W = 20,
    parameter int PAD_W  = 4,
    localparam int FRAME_W = DATA_W + PAD_W,
    localparam int CNT_W   = rdy_dout_pkg::cnt_width(FRAME_W)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_stb,
    input  logic [DATA_W-1:0] load_data,
    input  logic              upd_win,
    input  logic              sclk_rise,
    output logic              data_valid,
    output logic [CNT_W-1:0]  bit_cnt,
    output logic              head_bit
);
    localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(FRAME_W);

    logic [DATA_W-1:0] sreg;

    // Shift register: load, or shift left with one-fill after the first edge.
    always_ff @(posedge clk) begin
        if (!rst_n)
            sreg <= '1;
        else if (load_stb)
            sreg <= load_data;
        else if (sclk_rise && data_valid && bit_cnt != '0)
            sreg <= {sreg[DATA_W-2:0], 1'b1};
    end

    // Edge counter: cleared on load, saturates at the frame length.
    always_ff @(posedge clk) begin
        if (!rst_n)
            bit_cnt <= '0;
        else if (load_stb)
            bit_cnt <= '0;
        else if (sclk_rise && data_valid && bit_cnt != CNT_MAX)
            bit_cnt <= bit_cnt + 1'b1;
    end

    // Pending flag: set by a load, cleared by the update window.
    always_ff @(posedge clk) begin
        if (!rst_n)        data_valid <= 1'b0;
        else if (load_stb) data_valid <= 1'b1;
        else if (upd_win)  data_valid <= 1'b0;
    end

    // Current serial bit.
    always_comb head_bit = sreg[DATA_W-1];
endmodule

// File: rtl/rdy_pin_mux.sv
// Module: chooses between the ready level, a data bit and the idle high.
// Assumes bit_cnt == 0 means the ready phase of a pending result.
module rdy_pin_mux #(
    parameter int CNT_W = 5
) (
    input  logic             upd_win,
    input  logic             data_valid,
    input  logic [CNT_W-1:0] bit_cnt,
    input  logic             head_bit,
    output logic             pin_val
);
    // Pin level: idle/update high, ready low, else current bit.
    always_comb begin
        if (upd_win || !data_valid) pin_val = 1'b1;
        else if (bit_cnt == '0)     pin_val = 1'b0;
        else                        pin_val = head_bit;
    end
endmodule

// File: rtl/rdy_dout_port.sv
// Module: top of the shared ready/data output pin.
// Assumes load_stb is a single-cycle pulse in the clk domain.
module rdy_dout_port #(
    parameter int DATA_W = rdy_dout_pkg::DEF_DATA_W,
    parameter int PAD_W  = rdy_dout_pkg::DEF_PAD_W,
    parameter int SYNC_N = rdy_dout_pkg::DEF_SYNC_N
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load_stb,
    input  logic [DATA_W-1:0] load_data,
    input  logic              upd_win,
    input  logic              sclk_in,
    output logic              dout_pin
);
    localparam int FRAME_W = DATA_W + PAD_W;
    localparam int CNT_W   = rdy_dout_pkg::cnt_width(FRAME_W);

    logic             sclk_rise;
    logic             data_valid;
    logic [CNT_W-1:0] bit_cnt;
    logic             head_bit;

    rdy_sync_edge #(.SYNC_N(SYNC_N)) u_sync (
        .clk(clk), .rst_n(rst_n), .async_in(sclk_in), .rise_pulse(sclk_rise)
    );

    rdy_shift_core #(.DATA_W(DATA_W), .PAD_W(PAD_W)) u_core (
        .clk(clk), .rst_n(rst_n), .load_stb(load_stb), .load_data(load_data),
        .upd_win(upd_win), .sclk_rise(sclk_rise), .data_valid(data_valid),
        .bit_cnt(bit_cnt), .head_bit(head_bit)
    );

    rdy_pin_mux #(.CNT_W(CNT_W)) u_mux (
        .upd_win(upd_win), .data_valid(data_valid), .bit_cnt(bit_cnt),
        .head_bit(head_bit), .pin_val(dout_pin)
    );
endmodule

// File: rtl/rdy_dout_port_chk.sv
// Checker: cycle rules for the shared ready/data pin, bound to the top.
module rdy_dout_port_chk #(
    parameter int DATA_W = 20,
    parameter int PAD_W  = 4,
    parameter int CNT_W  = 5
) (
    input logic             clk,
    input logic             rst_n,
    input logic             load_stb,
    input logic             upd_win,
    input logic             sclk_rise,
    input logic             data_valid,
    input logic [CNT_W-1:0] bit_cnt,
    input logic             dout_pin
);
    localparam int FRAME_W = DATA_W + PAD_W;

    AST_RST_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (dout_pin && !data_valid)); // R1
    AST_LOAD_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        load_stb |=> (upd_win || !dout_pin)); // R2
    AST_CNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
        (sclk_rise && data_valid && !load_stb && int'(bit_cnt) < FRAME_W)
        |=> (bit_cnt == $past(bit_cnt) + 1'b1)); // R4
    AST_PAD_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        (int'(bit_cnt) > DATA_W) |-> dout_pin); // R5
    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        int'(bit_cnt) <= FRAME_W); // R5
    AST_HOLD_PIN: assert property (@(posedge clk) disable iff (!rst_n)
        (!sclk_rise && !load_stb && !upd_win) |=> (upd_win || $stable(dout_pin))); // R6
    AST_UPD_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        upd_win |-> dout_pin); // R7
    AST_IDLE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        !data_valid |-> dout_pin); // R10
endmodule

bind rdy_dout_port rdy_dout_port_chk #(.DATA_W(DATA_W), .PAD_W(PAD_W), .CNT_W(CNT_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .load_stb(load_stb), .upd_win(upd_win),
    .sclk_rise(sclk_rise), .data_valid(data_valid), .bit_cnt(bit_cnt),
    .dout_pin(dout_pin)
);

// File: tb/rdy_dout_port_test.sv
module rdy_dout_port_test;
    localparam int DW = 20;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          load_stb = 1'b0;
    logic [DW-1:0] load_data = '0;
    logic          upd_win = 1'b0;
    logic          sclk_in = 1'b0;
    logic          dout_pin;

    int  total = 0;
    int  bad = 0;
    bit  done = 1'b0;

    // behavioural reference state
    logic [DW-1:0] m_word = '0;
    int            m_edges = 0;
    bit            m_pend = 1'b0;
    bit            m_hist[$] = '{0, 0, 0};

    rdy_dout_port uut (
        .clk(clk), .rst_n(rst_n), .load_stb(load_stb), .load_data(load_data),
        .upd_win(upd_win), .sclk_in(sclk_in), .dout_pin(dout_pin)
    );

    always #5 clk = ~clk;

    task automatic chk(input string tag, input logic act, input logic exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%0b exp=%0b t=%0t", tag, act, exp, $time);
        end
    endtask

    function automatic logic model_pin();
        if (upd_win || !m_pend) return 1'b1;
        if (m_edges == 0) return 1'b0;
        if (m_edges <= DW) return m_word[DW - m_edges];
        return 1'b1;
    endfunction

    // reference model update, one step per clock
    always @(posedge clk) begin
        if (!rst_n) begin
            m_hist = '{0, 0, 0};
            m_edges = 0;
            m_pend = 0;
        end else begin
            bit seen_rise;
            seen_rise = m_hist[1] && !m_hist[2];
            m_hist.push_front(sclk_in);
            void'(m_hist.pop_back());
            if (load_stb) begin
                m_word = load_data;
                m_edges = 0;
                m_pend = 1;
            end else begin
                bit was_pend;
                was_pend = m_pend;
                if (upd_win) m_pend = 0;
                if (seen_rise && was_pend && m_edges < DW + 4) m_edges++;
            end
        end
    end

    // per-cycle comparison against the model
    always @(negedge clk) begin
        if (rst_n && !done) chk("MODEL", dout_pin, model_pin());
    end

    task automatic do_load(input logic [DW-1:0] d);
        load_stb = 1'b1;
        load_data = d;
        @(negedge clk);
        load_stb = 1'b0;
    endtask

    task automatic pulse();
        sclk_in = 1'b1;
        repeat (4) @(negedge clk);
        sclk_in = 1'b0;
        repeat (4) @(negedge clk);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            total++;
            bad++;
            $display("FAIL watchdog expired");
            $display("  test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        logic [DW-1:0] w1, w2, w3, w4;
        w1 = 20'hA5C3B;
        w2 = 20'h0F0F0;
        w3 = 20'h12345;
        w4 = 20'h80000;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 reset idle high", dout_pin, 1'b1);

        pulse();
        chk("R10 edge without data", dout_pin, 1'b1);

        do_load(w1);
        chk("R2 ready low", dout_pin, 1'b0);
        for (int k = 1; k <= DW; k++) begin
            pulse();
            if (k == 1) chk("R3 MSB first", dout_pin, w1[DW-1]);
            else        chk("R4 next bit", dout_pin, w1[DW-k]);
        end
        repeat (10) @(negedge clk);
        chk("R6 holds last bit", dout_pin, w1[0]);
        upd_win = 1'b1;
        @(negedge clk);
        chk("R7 update forces high", dout_pin, 1'b1);
        @(negedge clk);
        upd_win = 1'b0;
        repeat (2) @(negedge clk);
        chk("R7 high after update", dout_pin, 1'b1);

        do_load(w2);
        for (int k = 1; k <= 26; k++) begin
            pulse();
            if (k == 21) chk("R5 21st edge high", dout_pin, 1'b1);
            if (k == 24) chk("R5 24th edge high", dout_pin, 1'b1);
            if (k == 26) chk("R5 extra edges high", dout_pin, 1'b1);
        end

        do_load(w3);
        repeat (5) pulse();
        do_load(w1);
        chk("R8 overwrite ready low", dout_pin, 1'b0);
        pulse();
        chk("R8 new MSB", dout_pin, w1[DW-1]);

        do_load(w4);
        sclk_in = 1'b1;
        @(negedge clk);
        @(negedge clk);
        chk("R9 not yet shifted", dout_pin, 1'b0);
        @(negedge clk);
        chk("R9 third edge shows MSB", dout_pin, 1'b1);
        repeat (20) @(negedge clk);
        chk("R9 level shifts once", dout_pin, 1'b1);
        sclk_in = 1'b0;
        repeat (4) @(negedge clk);
        pulse();
        chk("R4 second bit after hold", dout_pin, w4[DW-2]);

        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule